// File: doc/BRIEF.md
# Two-Operand ALU with Status Flags

This block is the arithmetic and logic stage for the twelve two-operand operations of a 16-bit processor. It is purely combinational. It takes a 4-bit operation code, a byte/word select, a source value, a destination value and the incoming carry. It returns the result, a write-back enable, and new values for the negative (N), zero (Z), carry (C) and overflow (V) flags. Each flag also has an update mask bit that says whether the flag should be written.

The surrounding datapath supplies the operands after address resolution. It writes `result` into the destination when `wr_en` is high. It merges each flag into the status register only where the matching `upd_*` bit is high. Operand fetch, addressing modes and the register file are outside this block.

The data width is a parameter with a default of 16. Byte mode always works on the low 8 bits.

Top module: `alu2_core`

## Requirements
- R1: The operation codes are 0x4 move (`result = src`), 0x5 add, 0x6 add-with-carry, 0x7 subtract-with-carry, 0x8 subtract, 0x9 compare, 0xA decimal add, 0xB bit test, 0xC clear-bits (`~src & dst`), 0xD set-bits (`src | dst`), 0xE exclusive-or and 0xF and.
- R2: The arithmetic results are as follows. Add gives src+dst. Add-with-carry gives src+dst+c_in. Subtract-with-carry gives dst+~src+c_in. Subtract and compare give dst+~src+1.
- R3: For the five binary add and subtract operations, C is the carry out of the top bit of the selected width (for subtraction, 1 means no borrow). V is two's-complement overflow at that width.
- R4: Decimal add sums src, dst and c_in one 4-bit digit at a time. A digit sum above 9 is corrected by adding 6 and carries into the next digit. C is the carry out of the top digit. V is not updated.
- R5: When `byte_mode` is 1, only bits 7:0 of the operands take part, bits 15:8 of the result are 0, and N, C and V come from bit 7.
- R6: Whenever N or Z is updated, N equals the top bit of the result at the selected width, and Z is 1 exactly when that result is zero.
- R7: The bit-test and and operations clear V and set C to NOT Z. The exclusive-or operation sets C to NOT Z and sets V when both operands' top bits are 1.
- R8: Move, clear-bits and set-bits update no flag: all four `upd_*` bits are 0.
- R9: `wr_en` is 0 for compare and bit-test, and 1 for the other ten operations.
- R10: Operation codes 0x0 to 0x3 produce `result` = 0, `wr_en` = 0 and no flag updates.
- R11: Any flag output whose update bit is 0 is driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code (see R1) |
| byte_mode | input | 1 | 1 = byte width, 0 = word width |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| c_in | input | 1 | Incoming carry flag |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Destination write-back enable |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| v_out | output | 1 | New overflow flag |
| upd_n | output | 1 | Write enable for N |
| upd_z | output | 1 | Write enable for Z |
| upd_c | output | 1 | Write enable for C |
| upd_v | output | 1 | Write enable for V |

## Verification
The embedded checks assume that every input is a settled, known value whenever they evaluate. The bench therefore changes all inputs together on one clock edge and reads the outputs half a period later.

The checks assume nothing about whether the decimal-add digits are valid BCD. Non-decimal digit values are still corrected by the rule in R4, so the bench uses legal BCD operands only when it predicts exact decimal sums.

Operation codes 0x0 to 0x3 are applied on purpose to cover R10.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

   typedef enum logic [3:0] {
      OP_MOVE = 4'h4,
      OP_ADD  = 4'h5,
      OP_ADDC = 4'h6,
      OP_SUBC = 4'h7,
      OP_SUB  = 4'h8,
      OP_CMP  = 4'h9,
      OP_DADD = 4'hA,
      OP_TEST = 4'hB,
      OP_CLR  = 4'hC,
      OP_SET  = 4'hD,
      OP_XOR  = 4'hE,
      OP_AND  = 4'hF
   } alu2_op_e;

   typedef struct packed {
      logic v;
      logic n;
      logic z;
      logic c;
   } alu2_flags_t;

endpackage

// File: rtl/alu2_binadd.sv
module alu2_binadd #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              byte_mode,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   localparam int HI_W = DATA_W - LANE_W;

   logic [DATA_W:0] wide;
   logic [LANE_W:0] narrow;

   assign wide   = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
   assign narrow = {1'b0, a[LANE_W-1:0]} + {1'b0, b[LANE_W-1:0]} + {{LANE_W{1'b0}}, cin};

   always_comb begin
      if (byte_mode) begin
         sum  = {{HI_W{1'b0}}, narrow[LANE_W-1:0]};
         cout = narrow[LANE_W];
         ovf  = (a[LANE_W-1] == b[LANE_W-1]) && (narrow[LANE_W-1] != a[LANE_W-1]);
      end else begin
         sum  = wide[DATA_W-1:0];
         cout = wide[DATA_W];
         ovf  = (a[DATA_W-1] == b[DATA_W-1]) && (wide[DATA_W-1] != a[DATA_W-1]);
      end
   end

   // A byte sum never produces upper bits
   always_comb begin
      AST_BYTE_SUM_NARROW: assert (!byte_mode || sum[DATA_W-1:LANE_W] == '0); // R5
   end

endmodule

// File: rtl/alu2_bcdadd.sv
module alu2_bcdadd #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              byte_mode,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);
   localparam int DIGITS   = DATA_W / 4;
   localparam int LANE_DIG = LANE_W / 4;
   localparam int HI_W     = DATA_W - LANE_W;

   logic [DIGITS:0]   chain;
   logic [DATA_W-1:0] raw;

   assign chain[0] = cin;

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic [4:0] part;
      logic       fix;
      assign part = {1'b0, a[4*d +: 4]} + {1'b0, b[4*d +: 4]} + {4'b0, chain[d]};
      assign fix  = (part > 5'd9);
      assign raw[4*d +: 4] = fix ? (part[3:0] + 4'd6) : part[3:0];
      assign chain[d+1]    = fix;
   end

   assign sum  = byte_mode ? {{HI_W{1'b0}}, raw[LANE_W-1:0]} : raw;
   assign cout = byte_mode ? chain[LANE_DIG] : chain[DIGITS];

   // Each corrected digit must land in decimal range when its inputs are decimal
   for (genvar d = 0; d < DIGITS; d++) begin : g_chk
      always_comb begin
         AST_DIGIT_DECIMAL: assert (a[4*d +: 4] > 4'd9 || b[4*d +: 4] > 4'd9
                                    || raw[4*d +: 4] <= 4'd9); // R4
      end
   end

endmodule

// File: rtl/alu2_bitwise.sv
module alu2_bitwise
   import alu2_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu2_op_e          op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (op)
         OP_MOVE:         y = a;
         OP_TEST, OP_AND: y = a & b;
         OP_CLR:          y = ~a & b;
         OP_SET:          y = a | b;
         OP_XOR:          y = a ^ b;
         default:         y = '0;
      endcase
   end
endmodule

// File: rtl/alu2_core.sv
module alu2_core
   import alu2_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [3:0]        op,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   input  logic              c_in,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              n_out,
   output logic              z_out,
   output logic              c_out,
   output logic              v_out,
   output logic              upd_n,
   output logic              upd_z,
   output logic              upd_c,
   output logic              upd_v
);
   localparam int LANE_W = 8;
   localparam int HI_W   = DATA_W - LANE_W;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("alu2_core: DATA_W must be a multiple of 8 and at least 16");
   end

   alu2_op_e          opc;
   logic [DATA_W-1:0] width_mask;
   logic [DATA_W-1:0] add_a;
   logic              add_cin;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic              add_ovf;
   logic [DATA_W-1:0] bcd_sum;
   logic              bcd_cout;
   logic [DATA_W-1:0] bit_y;
   logic [DATA_W-1:0] res_sel;
   logic              top_res;
   logic              top_src;
   logic              top_dst;
   logic              is_zero;
   logic              is_sub;
   alu2_flags_t       fval;
   alu2_flags_t       fupd;

   assign opc        = alu2_op_e'(op);
   assign width_mask = byte_mode ? {{HI_W{1'b0}}, {LANE_W{1'b1}}} : {DATA_W{1'b1}};
   assign is_sub     = (opc == OP_SUBC) || (opc == OP_SUB) || (opc == OP_CMP);
   assign add_a      = is_sub ? ~src : src;

   always_comb begin
      unique case (opc)
         OP_ADDC, OP_SUBC:  add_cin = c_in;
         OP_SUB, OP_CMP:    add_cin = 1'b1;
         default:           add_cin = 1'b0;
      endcase
   end

   alu2_binadd #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_add (
      .a         (add_a),
      .b         (dst),
      .cin       (add_cin),
      .byte_mode (byte_mode),
      .sum       (add_sum),
      .cout      (add_cout),
      .ovf       (add_ovf)
   );

   alu2_bcdadd #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_bcd (
      .a         (src),
      .b         (dst),
      .cin       (c_in),
      .byte_mode (byte_mode),
      .sum       (bcd_sum),
      .cout      (bcd_cout)
   );

   alu2_bitwise #(.DATA_W(DATA_W)) u_bit (
      .op (opc),
      .a  (src),
      .b  (dst),
      .y  (bit_y)
   );

   always_comb begin
      unique case (opc)
         OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP: res_sel = add_sum;
         OP_DADD:                                  res_sel = bcd_sum;
         default:                                  res_sel = bit_y;
      endcase
   end

   assign result  = res_sel & width_mask;
   assign top_res = byte_mode ? result[LANE_W-1] : result[DATA_W-1];
   assign top_src = byte_mode ? src[LANE_W-1]    : src[DATA_W-1];
   assign top_dst = byte_mode ? dst[LANE_W-1]    : dst[DATA_W-1];
   assign is_zero = (result == '0);

   always_comb begin
      fval  = '0;
      fupd  = '0;
      wr_en = 1'b1;
      unique case (opc)
         OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP: begin
            fupd = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            fval = '{v: add_ovf, n: top_res, z: is_zero, c: add_cout};
            wr_en = (opc != OP_CMP);
         end
         OP_DADD: begin
            fupd = '{v: 1'b0, n: 1'b1, z: 1'b1, c: 1'b1};
            fval = '{v: 1'b0, n: top_res, z: is_zero, c: bcd_cout};
         end
         OP_TEST, OP_AND: begin
            fupd = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            fval = '{v: 1'b0, n: top_res, z: is_zero, c: !is_zero};
            wr_en = (opc != OP_TEST);
         end
         OP_XOR: begin
            fupd = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            fval = '{v: top_src & top_dst, n: top_res, z: is_zero, c: !is_zero};
         end
         OP_MOVE, OP_CLR, OP_SET: begin
            fupd = '0;
         end
         default: begin
            wr_en = 1'b0;
         end
      endcase
   end

   assign n_out = fval.n;
   assign z_out = fval.z;
   assign c_out = fval.c;
   assign v_out = fval.v;
   assign upd_n = fupd.n;
   assign upd_z = fupd.z;
   assign upd_c = fupd.c;
   assign upd_v = fupd.v;

   always_comb begin
      AST_UPPER_CLEAR: assert (!byte_mode || result[DATA_W-1:LANE_W] == '0); // R5
      AST_N_FROM_RESULT: assert (!upd_n || n_out == (byte_mode ? result[LANE_W-1]
                                                              : result[DATA_W-1])); // R6
      AST_Z_FROM_RESULT: assert (!upd_z || z_out == (result == '0)); // R6
      AST_NO_STORE_CMP_TEST: assert (!(op == 4'h9 || op == 4'hB) || !wr_en); // R9
      AST_QUIET_FLAGS: assert (!(op == 4'h4 || op == 4'hC || op == 4'hD)
                               || !(upd_n || upd_z || upd_c || upd_v)); // R8
      AST_C_IS_NOT_Z: assert (!(op == 4'hB || op == 4'hE || op == 4'hF)
                              || c_out == !z_out); // R7
      AST_LOW_CODES_IDLE: assert (op >= 4'h4 || (!wr_en && result == '0)); // R10
      AST_MASKED_LOW: assert ((upd_n || !n_out) && (upd_z || !z_out)
                              && (upd_c || !c_out) && (upd_v || !v_out)); // R11
   end

endmodule

// File: tb/tb_alu2_core.sv
module tb_alu2_core;

   typedef struct packed {
      logic [3:0]  op;
      logic        bm;
      logic [15:0] s;
      logic [15:0] d;
      logic        ci;
      logic [15:0] res;
      logic        we;
      logic [3:0]  fl;   // {V,N,Z,C}
      logic [3:0]  mk;   // {V,N,Z,C}
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{4'h4,1'b0,16'h1234,16'hFFFF,1'b0,16'h1234,1'b1,4'h0,4'h0}, // R1 R8 R11
      '{4'h5,1'b0,16'h7FFF,16'h0001,1'b0,16'h8000,1'b1,4'hC,4'hF}, // R2 R3
      '{4'h5,1'b0,16'hFFFF,16'h0001,1'b0,16'h0000,1'b1,4'h3,4'hF}, // R3 R6
      '{4'h6,1'b0,16'h0001,16'h0001,1'b1,16'h0003,1'b1,4'h0,4'hF}, // R2
      '{4'h7,1'b0,16'h0001,16'h0003,1'b0,16'h0001,1'b1,4'h1,4'hF}, // R2 R3
      '{4'h8,1'b0,16'h0005,16'h0003,1'b0,16'hFFFE,1'b1,4'h4,4'hF}, // R2 R3
      '{4'h9,1'b0,16'h0001,16'h8000,1'b0,16'h7FFF,1'b0,4'h9,4'hF}, // R3 R9
      '{4'hA,1'b0,16'h0199,16'h0001,1'b0,16'h0200,1'b1,4'h0,4'h7}, // R4
      '{4'hA,1'b1,16'h0099,16'h0001,1'b0,16'h0000,1'b1,4'h3,4'h7}, // R4 R5
      '{4'hA,1'b0,16'h9999,16'h0000,1'b1,16'h0000,1'b1,4'h3,4'h7}, // R4
      '{4'hB,1'b0,16'h00F0,16'h0F0F,1'b0,16'h0000,1'b0,4'h2,4'hF}, // R7 R9
      '{4'hC,1'b0,16'h00FF,16'h1234,1'b1,16'h1200,1'b1,4'h0,4'h0}, // R1 R8
      '{4'hD,1'b0,16'h000F,16'h1230,1'b1,16'h123F,1'b1,4'h0,4'h0}, // R1 R8
      '{4'hE,1'b0,16'h8000,16'h8001,1'b0,16'h0001,1'b1,4'h9,4'hF}, // R7
      '{4'hE,1'b0,16'h1234,16'h1234,1'b0,16'h0000,1'b1,4'h2,4'hF}, // R7 R6
      '{4'hF,1'b0,16'h8F00,16'h8100,1'b0,16'h8100,1'b1,4'h5,4'hF}, // R7 R1
      '{4'h5,1'b1,16'hAB7F,16'hCD01,1'b0,16'h0080,1'b1,4'hC,4'hF}, // R5 R3
      '{4'h8,1'b1,16'h0001,16'h0000,1'b0,16'h00FF,1'b1,4'h4,4'hF}, // R5
      '{4'h5,1'b1,16'h12FF,16'h3401,1'b0,16'h0000,1'b1,4'h3,4'hF}, // R5 R3
      '{4'h4,1'b1,16'hABCD,16'h0000,1'b0,16'h00CD,1'b1,4'h0,4'h0}, // R5 R1
      '{4'h2,1'b0,16'h1234,16'h5678,1'b1,16'h0000,1'b0,4'h0,4'h0}, // R10
      '{4'hF,1'b1,16'hFF80,16'hFF80,1'b0,16'h0080,1'b1,4'h5,4'hF}, // R5 R7
      '{4'h7,1'b0,16'h0000,16'h0000,1'b1,16'h0000,1'b1,4'h3,4'hF}  // R2 R3
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op;
   logic        byte_mode;
   logic [15:0] src;
   logic [15:0] dst;
   logic        c_in;
   logic [15:0] result;
   logic        wr_en;
   logic        n_out, z_out, c_out, v_out;
   logic        upd_n, upd_z, upd_c, upd_v;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   alu2_core dut (
      .op(op), .byte_mode(byte_mode), .src(src), .dst(dst), .c_in(c_in),
      .result(result), .wr_en(wr_en),
      .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out),
      .upd_n(upd_n), .upd_z(upd_z), .upd_c(upd_c), .upd_v(upd_v)
   );

   function automatic string req_of(input logic [3:0] o, input logic b);
      if (b) return "R5";
      case (o)
         4'h4, 4'hC, 4'hD: return "R8";
         4'h5, 4'h6, 4'h7, 4'h8: return "R3";
         4'h9: return "R9";
         4'hA: return "R4";
         4'hB, 4'hE, 4'hF: return "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic apply(input vec_t v);
      @(posedge clk);
      op = v.op; byte_mode = v.bm; src = v.s; dst = v.d; c_in = v.ci;
      @(negedge clk);
   endtask

   task automatic compare(input string tag, input vec_t v);
      logic [24:0] got, exp;
      got = {result, wr_en, v_out, n_out, z_out, c_out, upd_v, upd_n, upd_z, upd_c};
      exp = {v.res, v.we, v.fl, v.mk};
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s op=%h: got res=%h we=%b f=%b m=%b, expected res=%h we=%b f=%b m=%b",
                  tag, v.op, got[24:9], got[8], got[7:4], got[3:0],
                  exp[24:9], exp[8], exp[7:4], exp[3:0]);
      end
   endtask

   initial begin
      op = 4'h0; byte_mode = 1'b0; src = '0; dst = '0; c_in = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state, idle code 0: R10 / R11
      compare("R10", '{4'h0,1'b0,16'h0,16'h0,1'b0,16'h0000,1'b0,4'h0,4'h0});

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         compare(req_of(VEC[i].op, VEC[i].bm), VEC[i]);
      end

      // R10: all low codes idle, carry-in high and operands busy
      for (int k = 0; k < 4; k++) begin
         vec_t v;
         v = '{k[3:0],1'b0,16'hFFFF,16'hFFFF,1'b1,16'h0000,1'b0,4'h0,4'h0};
         apply(v);
         compare("R10", v);
      end

      // R2: add-with-carry wraps to zero with carry out
      apply('{4'h6,1'b0,16'hFFFF,16'h0000,1'b1,16'h0000,1'b1,4'h3,4'hF});
      compare("R2", '{4'h6,1'b0,16'hFFFF,16'h0000,1'b1,16'h0000,1'b1,4'h3,4'hF});

      // R4: decimal add, top digit negative result in byte mode, V never updated
      apply('{4'hA,1'b1,16'h0045,16'h0045,1'b0,16'h0090,1'b1,4'h4,4'h7});
      compare("R4", '{4'hA,1'b1,16'h0045,16'h0045,1'b0,16'h0090,1'b1,4'h4,4'h7});

      // R9: bit test with nonzero result, still no write-back
      apply('{4'hB,1'b1,16'h0081,16'h0080,1'b0,16'h0080,1'b0,4'h5,4'hF});
      compare("R9", '{4'hB,1'b1,16'h0081,16'h0080,1'b0,16'h0080,1'b0,4'h5,4'hF});

      // R6: subtract equal operands gives zero and no borrow
      apply('{4'h8,1'b0,16'h4321,16'h4321,1'b0,16'h0000,1'b1,4'h3,4'hF});
      compare("R6", '{4'h8,1'b0,16'h4321,16'h4321,1'b0,16'h0000,1'b1,4'h3,4'hF});

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, got no completion, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule